// File: doc/BRIEF.md
# Dual-Channel Supply Supervisor Reset Controller

This block is the digital core of a supply supervisor. It takes two already-digitised channel readings, as unsigned 12-bit codes at 1 mV per LSB, and one flag that says the local supply is above its lockout level. From these it drives one status bit per channel and an active-low reset. Each channel is compared against a fixed threshold. A two-bit selector picks the polarity of each channel: positive channels must sit above the threshold, negative channels below it. Every comparison passes through a glitch filter before it can change that channel's validity.

The reset output is held low until both channels and the supply flag have stayed good for a timeout period, and it drops again as soon as any of them goes bad. The timeout can be a fixed internal period or a programmable multiple of a unit period with a floor. It can also be switched off, in which case reset simply follows the combined validity; only in that mode do the comparisons gain one-sided hysteresis. The selector and the timeout mode are captured once, at the first cycle the supply flag is seen high. Before that, every output is held low.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_i` is high, and after reset until `supply_ok_i` is first sampled high, `ch_ok_o` is 2'b00 and `rst_n_o` is 0.
- R2: On the first clock edge with `supply_ok_i` high, polarity is captured from `sel_i`: 2'b00 makes both channels positive, 2'b01 makes channel 0 positive and channel 1 negative, 2'b10 or 2'b11 makes both negative. Later changes of `sel_i` and `tmode_i` have no effect until the next reset.
- R3: A positive channel is good when its code is strictly greater than THRESH (500). A negative channel is good when its code is strictly less than THRESH. A code of exactly 500 is bad for both polarities.
- R4: A channel's validity changes only after its comparison result has disagreed with it on FILT_CYC consecutive clock edges (150 us worth of clock). A shorter excursion leaves it unchanged.
- R5: `ch_ok_o[i]` (bit 0 for channel 0) equals that channel's filtered validity and does not depend on the timer, the timeout mode or `supply_ok_i`.
- R6: One clock edge after any channel turns bad, or after `supply_ok_i` is sampled low, `rst_n_o` is 0.
- R7: The timer restarts from zero after every interruption. `rst_n_o` rises on the P-th consecutive edge at which both channels are good and `supply_ok_i` is high.
- R8: When `tmode_i` is 2'b00 (internal), P is the number of clock cycles in 200 ms.
- R9: When `tmode_i` is 2'b01 (external), P is `ext_period_i` times the cycles in 9 ms, but at least the cycles in 400 us. `ext_period_i` is sampled on the edge where the count starts.
- R10: When `tmode_i` is 2'b10 or 2'b11 (pass-through), `rst_n_o` is the combined validity delayed by one clock.
- R11: Only in pass-through mode, a bad channel becomes good only past a margin of HYST (3) codes: above 503 for positive, below 497 for negative. The good-to-bad threshold stays at 500. In timed modes there is no margin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Local supply above lockout level |
| code_i | input | 2x12 | Channel readings, channel 0 in the low element |
| sel_i | input | 2 | Polarity selector (three-valued, see R2) |
| tmode_i | input | 2 | Timeout mode (see R8 to R10) |
| ext_period_i | input | 16 | Programmable timeout, in 9 ms units |
| ch_ok_o | output | 2 | Per-channel good status, high when good |
| rst_n_o | output | 1 | Active-low reset |

## Verification
A filter counter that is stuck or off by one moves the edge at which `ch_ok_o` changes, so it shows at the ports FILT_CYC edges after an input step, or as a short glitch that gets through. A timer that fails to clear on an interruption, or that samples the wrong period, moves the rising edge of `rst_n_o` away from exactly P edges after the last return to good; this shows up only once that full period has passed. A wrong polarity or hysteresis state shows within one filter window as a status bit that does not match the code that was applied. A configuration that is recaptured late shows as a status change after the selector moves.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

    typedef enum logic [1:0] {
        TM_INTERNAL   = 2'b00,
        TM_EXTERNAL   = 2'b01,
        TM_BYPASS     = 2'b10,
        TM_BYPASS_ALT = 2'b11
    } tmode_e;

    typedef struct packed {
        pol_e ch1;
        pol_e ch0;
    } pol_pair_t;

    typedef struct packed {
        pol_pair_t pol;
        tmode_e    mode;
    } cfg_t;

    // Three-valued selector: low -> both positive, high -> ch0 pos / ch1 neg,
    // open (either remaining code) -> both negative.
    function automatic pol_pair_t decode_sel(input logic [1:0] s);
        pol_pair_t p;
        case (s)
            2'b00:   begin p.ch0 = POL_POS; p.ch1 = POL_POS; end
            2'b01:   begin p.ch0 = POL_POS; p.ch1 = POL_NEG; end
            default: begin p.ch0 = POL_NEG; p.ch1 = POL_NEG; end
        endcase
        return p;
    endfunction

    // Raw comparison. The margin only applies on the bad-to-good direction.
    function automatic logic cmp_good(input int unsigned code,
                                      input pol_e        pol,
                                      input logic        was_good,
                                      input logic        hyst_on,
                                      input int unsigned thr,
                                      input int unsigned hy);
        int unsigned margin;
        margin = (hyst_on && !was_good) ? hy : 0;
        if (pol == POL_POS) return code > thr + margin;
        else                return code + margin < thr;
    endfunction

    function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                     input longint unsigned us);
        return (clk_hz * us) / 64'd1_000_000;
    endfunction

    function automatic longint unsigned at_least_one(input longint unsigned v);
        return (v == 0) ? 64'd1 : v;
    endfunction

endpackage

// File: rtl/supv_chan_filter.sv
module supv_chan_filter
    import supv_pkg::*;
#(
    parameter int              CODE_W   = 12,
    parameter int unsigned     THRESH   = 500,
    parameter int unsigned     HYST     = 3,
    parameter longint unsigned FILT_CYC = 150
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    input  pol_e              pol_i,
    input  logic              hyst_on_i,
    output logic              good_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [CW-1:0] run_q;
    logic          raw;

    always_comb begin
        raw = cmp_good(32'(code_i), pol_i, good_o, hyst_on_i, THRESH, HYST);
    end

    // Saturating agreement counter: validity flips after FILT_CYC
    // consecutive disagreeing samples, in either direction.
    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            good_o <= 1'b0;
            run_q  <= '0;
        end else if (raw == good_o) begin
            run_q  <= '0;
        end else if (run_q == CW'(FILT_CYC - 1)) begin
            good_o <= raw;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/supv_reset_timer.sv
module supv_reset_timer
    import supv_pkg::*;
#(
    parameter int              CNT_W    = 30,
    parameter int              SET_W    = 16,
    parameter longint unsigned INT_CYC  = 200000,
    parameter longint unsigned UNIT_CYC = 9000,
    parameter longint unsigned MIN_CYC  = 400
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             all_ok_i,
    input  tmode_e           mode_i,
    input  logic [SET_W-1:0] ext_set_i,
    output logic             rst_n_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic             run_q;
    logic [CNT_W-1:0] ext_p;
    logic [CNT_W-1:0] p_now;
    logic [CNT_W-1:0] eff_tgt;
    logic             bypass;

    always_comb begin
        bypass = (mode_i == TM_BYPASS) || (mode_i == TM_BYPASS_ALT);
        ext_p  = CNT_W'(ext_set_i) * CNT_W'(UNIT_CYC);
        if (ext_p < CNT_W'(MIN_CYC)) ext_p = CNT_W'(MIN_CYC);
        p_now   = (mode_i == TM_EXTERNAL) ? ext_p : CNT_W'(INT_CYC);
        eff_tgt = run_q ? tgt_q : p_now;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            tgt_q   <= '0;
            run_q   <= 1'b0;
            rst_n_o <= 1'b0;
        end else if (bypass) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            rst_n_o <= all_ok_i;
        end else if (!all_ok_i) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            rst_n_o <= 1'b0;
        end else if (!rst_n_o) begin
            if (cnt_q + 1'b1 >= eff_tgt) begin
                rst_n_o <= 1'b1;
                run_q   <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                run_q <= 1'b1;
                if (!run_q) tgt_q <= p_now;
            end
        end
    end

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 1_000_000,
    parameter int              CODE_W  = 12,
    parameter int unsigned     THRESH  = 500,
    parameter int unsigned     HYST    = 3,
    parameter longint unsigned FILT_US = 150,
    parameter longint unsigned INT_MS  = 200,
    parameter longint unsigned UNIT_US = 9000,
    parameter longint unsigned MIN_US  = 400,
    parameter int              SET_W   = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   supply_ok_i,
    input  logic [1:0][CODE_W-1:0] code_i,
    input  logic [1:0]             sel_i,
    input  logic [1:0]             tmode_i,
    input  logic [SET_W-1:0]       ext_period_i,
    output logic [1:0]             ch_ok_o,
    output logic                   rst_n_o
);
    localparam int              NCH      = 2;
    localparam longint unsigned FILT_CYC = at_least_one(us_to_cycles(CLK_HZ, FILT_US));
    localparam longint unsigned INT_CYC  = at_least_one(us_to_cycles(CLK_HZ, INT_MS * 1000));
    localparam longint unsigned UNIT_CYC = at_least_one(us_to_cycles(CLK_HZ, UNIT_US));
    localparam longint unsigned MIN_CYC  = at_least_one(us_to_cycles(CLK_HZ, MIN_US));
    localparam longint unsigned EXT_MAX  = ((64'd1 << SET_W) - 1) * UNIT_CYC;
    localparam longint unsigned P_MAX0   = (INT_CYC > EXT_MAX) ? INT_CYC : EXT_MAX;
    localparam longint unsigned P_MAX    = (P_MAX0 > MIN_CYC) ? P_MAX0 : MIN_CYC;
    localparam int              CNT_W    = $clog2(P_MAX + 1);

    logic           armed_q;
    cfg_t           cfg_q;
    logic [NCH-1:0] good;
    pol_e           pol_vec [NCH];
    logic           hyst_on;
    logic           all_ok;
    logic [1:0]     pol_bits;

    // Configuration capture at the first sight of a good supply.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q  <= 1'b0;
            cfg_q    <= '0;
        end else if (!armed_q && supply_ok_i) begin
            armed_q  <= 1'b1;
            cfg_q.pol  <= decode_sel(sel_i);
            cfg_q.mode <= tmode_e'(tmode_i);
        end
    end

    assign pol_vec[0] = cfg_q.pol.ch0;
    assign pol_vec[1] = cfg_q.pol.ch1;
    assign pol_bits   = {cfg_q.pol.ch1, cfg_q.pol.ch0};
    assign hyst_on    = armed_q &&
                        ((cfg_q.mode == TM_BYPASS) || (cfg_q.mode == TM_BYPASS_ALT));

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        supv_chan_filter #(
            .CODE_W  (CODE_W),
            .THRESH  (THRESH),
            .HYST    (HYST),
            .FILT_CYC(FILT_CYC)
        ) u_filt (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .en_i     (armed_q),
            .code_i   (code_i[g]),
            .pol_i    (pol_vec[g]),
            .hyst_on_i(hyst_on),
            .good_o   (good[g])
        );
    end

    assign all_ok  = armed_q && supply_ok_i && (&good);
    assign ch_ok_o = good & {NCH{armed_q}};

    supv_reset_timer #(
        .CNT_W   (CNT_W),
        .SET_W   (SET_W),
        .INT_CYC (INT_CYC),
        .UNIT_CYC(UNIT_CYC),
        .MIN_CYC (MIN_CYC)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .all_ok_i (all_ok),
        .mode_i   (cfg_q.mode),
        .ext_set_i(ext_period_i),
        .rst_n_o  (rst_n_o)
    );

endmodule

// File: rtl/supv_reset_ctrl_chk.sv
module supv_reset_ctrl_chk #(
    parameter longint unsigned FILT_CYC = 150
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       armed,
    input logic       all_ok,
    input logic [1:0] pol,
    input logic [1:0] ch_ok_o,
    input logic       rst_n_o
);
    localparam int SW = $clog2(FILT_CYC + 1) + 1;

    logic [1:0]    prev_ok;
    logic [SW-1:0] since0;
    logic [SW-1:0] since1;

    // Edges since each status bit last changed, saturating at FILT_CYC.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_ok <= 2'b00;
            since0  <= SW'(FILT_CYC);
            since1  <= SW'(FILT_CYC);
        end else begin
            prev_ok <= ch_ok_o;
            if (ch_ok_o[0] != prev_ok[0])       since0 <= '0;
            else if (since0 < SW'(FILT_CYC))    since0 <= since0 + 1'b1;
            if (ch_ok_o[1] != prev_ok[1])       since1 <= '0;
            else if (since1 < SW'(FILT_CYC))    since1 <= since1 + 1'b1;
        end
    end

    // R1
    a_r1_prearm_low: assert property (@(posedge clk_i) disable iff (rst_i)
        !armed |-> (rst_n_o == 1'b0 && ch_ok_o == 2'b00));

    // R2
    a_r2_pol_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && $past(armed)) |-> $stable(pol));

    // R4
    a_r4_filter_gap0: assert property (@(posedge clk_i) disable iff (rst_i)
        (ch_ok_o[0] != prev_ok[0]) |-> (since0 >= SW'(FILT_CYC - 1)));

    // R4
    a_r4_filter_gap1: assert property (@(posedge clk_i) disable iff (rst_i)
        (ch_ok_o[1] != prev_ok[1]) |-> (since1 >= SW'(FILT_CYC - 1)));

    // R6
    a_r6_bad_drops_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        !all_ok |=> !rst_n_o);

    // R7
    a_r7_release_needs_good: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> $past(all_ok));

endmodule

bind supv_reset_ctrl supv_reset_ctrl_chk #(.FILT_CYC(FILT_CYC)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .armed  (armed_q),
    .all_ok (all_ok),
    .pol    (pol_bits),
    .ch_ok_o(ch_ok_o),
    .rst_n_o(rst_n_o)
);

// File: tb/tb_supv_reset_ctrl.sv
module tb_supv_reset_ctrl;

    // 100 kHz nominal clock rate for the timing parameters keeps periods short.
    localparam int F    = 15;     // 150 us
    localparam int PINT = 20000;  // 200 ms
    localparam int UNIT = 900;    // 9 ms
    localparam int PMIN = 40;     // 400 us

    logic             clk = 1'b0;
    logic             rst;
    logic             supply_ok;
    logic [1:0][11:0] code;
    logic [1:0]       sel;
    logic [1:0]       tmode;
    logic [15:0]      ext_period;
    logic [1:0]       ch_ok;
    logic             rst_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [1:0] ok;
        logic       rn;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supv_reset_ctrl #(.CLK_HZ(100_000)) dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .supply_ok_i (supply_ok),
        .code_i      (code),
        .sel_i       (sel),
        .tmode_i     (tmode),
        .ext_period_i(ext_period),
        .ch_ok_o     (ch_ok),
        .rst_n_o     (rst_n)
    );

    // Monitor: pops every expectation due in this cycle and compares.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                checks++;
                if (ch_ok !== sb[i].ok || rst_n !== sb[i].rn) begin
                    failures++;
                    $display("FAIL %s: actual ch_ok=%b rst_n=%b expected ch_ok=%b rst_n=%b",
                             sb[i].tag, ch_ok, rst_n, sb[i].ok, sb[i].rn);
                end
                sb.delete(i);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver side: expectation d clock edges from now.
    task automatic expect_at(input int d, input logic [1:0] ok, input logic rn, input string tag);
        exp_t e;
        e.at = cyc + d; e.ok = ok; e.rn = rn; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic restart(input logic [1:0] s, input logic [1:0] m, input logic [15:0] ep,
                           input int c0, input int c1);
        rst = 1'b1; supply_ok = 1'b0;
        sel = s; tmode = m; ext_period = ep;
        code[0] = 12'(c0); code[1] = 12'(c1);
        tick(3);
        expect_at(0, 2'b00, 1'b0, "R1 outputs low in reset");
        tick(1);
        rst = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Internal timeout, both positive; 501 is good with no margin (R11).
        restart(2'b00, 2'b00, 16'd0, 600, 501);
        tick(50);
        expect_at(0, 2'b00, 1'b0, "R1 held low before supply good");
        tick(1);
        supply_ok = 1'b1;
        expect_at(F,          2'b00, 1'b0, "R4 filter not yet passed");
        expect_at(F + 1,      2'b11, 1'b0, "R3 R11 positive good, timed mode no margin");
        expect_at(F + PINT,   2'b11, 1'b0, "R8 still in timeout");
        expect_at(F + PINT+1, 2'b11, 1'b1, "R8 internal period release");
        tick(F + PINT + 3);

        code[0] = 12'd400;
        tick(F - 1);
        code[0] = 12'd600;
        expect_at(2, 2'b11, 1'b1, "R4 short glitch rejected");
        tick(F + 3);

        sel = 2'b10;
        expect_at(F + 5, 2'b11, 1'b1, "R2 selector change ignored after capture");
        tick(F + 6);

        code[0] = 12'd400;
        expect_at(F - 1, 2'b11, 1'b1, "R4 validity held until window full");
        expect_at(F,     2'b10, 1'b1, "R5 status drops after filter");
        expect_at(F + 1, 2'b10, 1'b0, "R6 reset asserts one edge later");
        tick(F + 3);

        code[0] = 12'd600;
        expect_at(F, 2'b11, 1'b0, "R5 status returns before timeout");
        tick(F + 100);
        supply_ok = 1'b0;
        tick(1);
        supply_ok = 1'b1;
        expect_at(0,     2'b11, 1'b0, "R5 status ignores supply flag");
        expect_at(PINT - 1, 2'b11, 1'b0, "R7 timer restarted from zero");
        expect_at(PINT,  2'b11, 1'b1, "R7 release after full restart");
        tick(PINT + 2);

        // External timeout, ch0 positive / ch1 negative.
        restart(2'b01, 2'b01, 16'd2, 600, 400);
        supply_ok = 1'b1;
        expect_at(F,              2'b00, 1'b0, "R4 filter not yet passed");
        expect_at(F + 1,          2'b11, 1'b0, "R2 R3 mixed polarity good");
        expect_at(F + 2*UNIT,     2'b11, 1'b0, "R9 external still counting");
        expect_at(F + 2*UNIT + 1, 2'b11, 1'b1, "R9 external period sampled at start");
        tick(F + 5);
        ext_period = 16'd0;
        tick(2*UNIT);

        code[1] = 12'd600;
        expect_at(F,     2'b01, 1'b1, "R3 negative channel bad above threshold");
        expect_at(F + 1, 2'b01, 1'b0, "R6 reset on channel loss");
        tick(F + 3);
        code[1] = 12'd400;
        expect_at(F - 1,    2'b01, 1'b0, "R4 recovery waits for filter");
        expect_at(F,        2'b11, 1'b0, "R5 status recovers");
        expect_at(F + PMIN - 1, 2'b11, 1'b0, "R9 minimum period holding");
        expect_at(F + PMIN, 2'b11, 1'b1, "R9 minimum period release");
        tick(F + PMIN + 2);

        // Pass-through, both negative, with margin.
        restart(2'b10, 2'b10, 16'd0, 498, 496);
        supply_ok = 1'b1;
        expect_at(F + 1, 2'b10, 1'b0, "R11 negative 498 not past margin");
        expect_at(F + 5, 2'b10, 1'b0, "R10 reset follows bad channel");
        tick(F + 6);
        code[0] = 12'd496;
        expect_at(F - 1, 2'b10, 1'b0, "R4 filter window");
        expect_at(F,     2'b11, 1'b0, "R11 past margin becomes good");
        expect_at(F + 1, 2'b11, 1'b1, "R10 pass-through one edge later");
        tick(F + 3);
        code[0] = 12'd498;
        expect_at(F + 5, 2'b11, 1'b1, "R11 good stays good inside margin");
        tick(F + 6);
        code[0] = 12'd500;
        expect_at(F - 1, 2'b11, 1'b1, "R4 filter window");
        expect_at(F,     2'b10, 1'b1, "R3 exactly threshold is bad");
        expect_at(F + 1, 2'b10, 1'b0, "R10 pass-through drop");
        tick(F + 3);

        // Pass-through, both positive, with margin.
        restart(2'b00, 2'b11, 16'd0, 502, 700);
        supply_ok = 1'b1;
        expect_at(F + 1, 2'b10, 1'b0, "R11 positive 502 not past margin");
        expect_at(F + 5, 2'b10, 1'b0, "R10 reset follows bad channel");
        tick(F + 6);
        code[0] = 12'd504;
        expect_at(F - 1, 2'b10, 1'b0, "R4 filter window");
        expect_at(F,     2'b11, 1'b0, "R11 positive past margin");
        expect_at(F + 1, 2'b11, 1'b1, "R10 pass-through release");
        tick(F + 3);
        code[0] = 12'd501;
        expect_at(F + 5, 2'b11, 1'b1, "R11 positive good stays inside margin");
        tick(F + 6);
        code[0] = 12'd500;
        expect_at(F,     2'b10, 1'b1, "R3 positive exactly threshold is bad");
        expect_at(F + 1, 2'b10, 1'b0, "R6 reset after loss");
        tick(F + 3);
        supply_ok = 1'b0;
        code[0] = 12'd600;
        expect_at(F + 5, 2'b11, 1'b0, "R6 supply low keeps reset low");
        tick(F + 7);

        for (int i = 0; i < sb.size(); i++) begin
            checks++;
            failures++;
            $display("FAIL %s: actual=unchecked expected=checked at %0d", sb[i].tag, sb[i].at);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule